// File: doc/BRIEF.md
# Maskable Interrupt Status Register Unit

This unit gathers four one-cycle event pulses from a serial audio style peripheral into sticky status flags. The four events are receive data available, receive overrun, transmit space available and transmit underrun. A mask selects which flags may raise the single interrupt line. Software never rewrites a whole register to change one bit. Four write-only command addresses set mask bits, clear mask bits, clear flags and force flags. Each write of a one acts only on the matching bit, so the result is the same whatever else software or hardware is doing to the other bits.

The register interface has one address, a write strobe and write data, and it returns read data combinationally from the address. The status flags and the mask are read-only views. The command addresses read as zero. The interrupt output is a flop, and it updates on the same clock edge as the flags and the mask. An asynchronous active-low reset clears everything. A two-stage synchronizer inside the unit releases that reset in step with the clock.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is active, and after it is released, every flag bit and every mask bit is zero and `irq` is low.
- R2: Each event input sets its own flag on the next clock edge. The flag bit positions are: bit 0 receive data available, bit 1 receive overrun, bit 2 transmit space available, bit 3 transmit underrun.
- R3: A flag that is set stays set through any number of cycles that have no flag-clear write for that bit.
- R4: A write to word address 2 (mask-on) sets each mask bit whose data bit is 1. Data bits that are 0, and data bits above bit 3, leave the mask unchanged.
- R5: A write to word address 3 (mask-off) clears each mask bit whose data bit is 1. Other mask bits keep their value.
- R6: After each clock edge, `irq` is high exactly when some flag bit and the mask bit at the same position are both 1.
- R7: A write to word address 4 (flag-clear) clears each flag bit whose data bit is 1. `irq` stays high until every unmasked flag has been cleared this way.
- R8: A write to word address 5 (flag-set) sets each flag bit whose data bit is 1. This forces an interrupt when that bit is unmasked.
- R9: If an event pulse and a flag-clear write hit the same bit in the same cycle, the bit is set after the edge.
- R10: Reading word address 0 returns the flags in bits 3:0, and reading word address 1 returns the mask in bits 3:0. All higher bits read as zero. Addresses 2 to 5 read as zero. A write to address 0 or 1 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register word address |
| reg_wr_en | input | 1 | Write strobe, sampled on the clock edge |
| reg_wr_data | input | DATA_W | Write data; bits 3:0 select sources |
| reg_rd_data | output | DATA_W | Read data for `reg_addr` |
| ev_rx_ready | input | 1 | Pulse: receive data available |
| ev_rx_overrun | input | 1 | Pulse: receive overrun |
| ev_tx_ready | input | 1 | Pulse: transmit space available |
| ev_tx_underrun | input | 1 | Pulse: transmit underrun |
| irq | output | 1 | Interrupt request |

## Verification
A wrong flag or mask bit cannot hide. It shows up on the flag or mask read address in the cycle after the edge that produced it, and the bench reads both addresses after every edge. An error in the mask gating or in the interrupt flop shows on `irq` at that same sampling point. The bench also varies the event pulses and the command writes over many cycles, so that a wrong priority between an event and a clear, or a command decoded at the wrong address, changes the next read.

// File: rtl/irq_status_pkg.sv
`timescale 1ns/1ps
package irq_status_pkg;
  localparam int unsigned NUM_SRC = 4;

  localparam int unsigned SRC_RX_READY   = 0;
  localparam int unsigned SRC_RX_OVERRUN = 1;
  localparam int unsigned SRC_TX_READY   = 2;
  localparam int unsigned SRC_TX_UNDERRUN = 3;

  localparam int unsigned OFS_FLAGS    = 0;
  localparam int unsigned OFS_MASK     = 1;
  localparam int unsigned OFS_MASK_ON  = 2;
  localparam int unsigned OFS_MASK_OFF = 3;
  localparam int unsigned OFS_FLAG_CLR = 4;
  localparam int unsigned OFS_FLAG_SET = 5;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_MASK_ON,
    OP_MASK_OFF,
    OP_FLAG_CLR,
    OP_FLAG_SET
  } wr_op_e;
endpackage

// File: rtl/irq_rst_sync.sv
`timescale 1ns/1ps
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] flags_d,
  output logic [N-1:0] flags_q
);
  logic upd_en;

  always_comb begin
    flags_d = flags_q;
    if (clr_en) flags_d = flags_d & ~wr_bits;
    if (set_en) flags_d = flags_d | wr_bits;
    flags_d = flags_d | ev;
    upd_en = clr_en | set_en | (|ev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev) |=> ((flags_q & $past(ev)) == $past(ev)));

  assert_flags_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en && ev == '0) |=> $stable(flags_q));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en && ev == '0) |=> ((flags_q & $past(wr_bits)) == '0));

  assert_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((flags_q & $past(wr_bits)) == $past(wr_bits)));

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && |(ev & wr_bits)) |=> ((flags_q & $past(ev & wr_bits)) == $past(ev & wr_bits)));
endmodule

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
module irq_mask_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         on_en,
  input  logic         off_en,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] mask_d,
  output logic [N-1:0] mask_q
);
  logic upd_en;

  always_comb begin
    mask_d = mask_q;
    if (on_en)  mask_d = mask_d | wr_bits;
    if (off_en) mask_d = mask_d & ~wr_bits;
    upd_en = on_en | off_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (upd_en) mask_q <= mask_d;
  end

  assert_mask_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    on_en |=> ((mask_q & $past(wr_bits)) == $past(wr_bits)));

  assert_mask_on_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (on_en && !off_en) |=> ((mask_q & ~$past(wr_bits)) == ($past(mask_q) & ~$past(wr_bits))));

  assert_mask_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    off_en |=> ((mask_q & $past(wr_bits)) == '0));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!on_en && !off_en) |=> $stable(mask_q));
endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flags_d,
  input  logic [N-1:0] mask_d,
  input  logic [N-1:0] flags_q,
  input  logic [N-1:0] mask_q,
  output logic         irq_q
);
  logic irq_d;
  logic unused_q;

  always_comb begin
    irq_d = |(flags_d & mask_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign unused_q = ^{flags_q, mask_q};

  assert_irq_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q == (|(flags_q & mask_q)));

  assert_irq_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & mask_q)) |-> irq_q);
endmodule

// File: rtl/irq_status_unit.sv
`timescale 1ns/1ps
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              ev_rx_ready,
  input  logic              ev_rx_overrun,
  input  logic              ev_tx_ready,
  input  logic              ev_tx_underrun,
  output logic              irq
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic               rst_n_s;
  logic [NUM_SRC-1:0] ev_vec;
  logic [NUM_SRC-1:0] wr_bits;
  logic [NUM_SRC-1:0] flags_d, flags_q;
  logic [NUM_SRC-1:0] mask_d, mask_q;
  wr_op_e             op;
  logic               unused_hi;

  irq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  always_comb begin
    ev_vec = '0;
    ev_vec[SRC_RX_READY]    = ev_rx_ready;
    ev_vec[SRC_RX_OVERRUN]  = ev_rx_overrun;
    ev_vec[SRC_TX_READY]    = ev_tx_ready;
    ev_vec[SRC_TX_UNDERRUN] = ev_tx_underrun;
  end

  assign wr_bits   = reg_wr_data[NUM_SRC-1:0];
  assign unused_hi = ^reg_wr_data[DATA_W-1:NUM_SRC];

  always_comb begin
    op = OP_IDLE;
    if (reg_wr_en) begin
      if      (reg_addr == ADDR_W'(OFS_MASK_ON))  op = OP_MASK_ON;
      else if (reg_addr == ADDR_W'(OFS_MASK_OFF)) op = OP_MASK_OFF;
      else if (reg_addr == ADDR_W'(OFS_FLAG_CLR)) op = OP_FLAG_CLR;
      else if (reg_addr == ADDR_W'(OFS_FLAG_SET)) op = OP_FLAG_SET;
    end
  end

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ev      (ev_vec),
    .set_en  (op == OP_FLAG_SET),
    .clr_en  (op == OP_FLAG_CLR),
    .wr_bits (wr_bits),
    .flags_d (flags_d),
    .flags_q (flags_q)
  );

  irq_mask_bank #(.N(NUM_SRC)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .on_en   (op == OP_MASK_ON),
    .off_en  (op == OP_MASK_OFF),
    .wr_bits (wr_bits),
    .mask_d  (mask_d),
    .mask_q  (mask_q)
  );

  irq_gate #(.N(NUM_SRC)) u_gate (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .flags_d (flags_d),
    .mask_d  (mask_d),
    .flags_q (flags_q),
    .mask_q  (mask_q),
    .irq_q   (irq)
  );

  always_comb begin
    if (reg_addr == ADDR_W'(OFS_FLAGS))     reg_rd_data = {{PAD_W{1'b0}}, flags_q};
    else if (reg_addr == ADDR_W'(OFS_MASK)) reg_rd_data = {{PAD_W{1'b0}}, mask_q};
    else                                    reg_rd_data = '0;
  end

  assert_ro_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr_en && (reg_addr == ADDR_W'(OFS_FLAGS) || reg_addr == ADDR_W'(OFS_MASK)) && ev_vec == '0)
      |=> ($stable(flags_q) && $stable(mask_q)));
endmodule

// File: tb/irq_status_unit_bench.sv
`timescale 1ns/1ps
module irq_status_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] reg_rd_data;
  logic        ev_rx_ready = 1'b0, ev_rx_overrun = 1'b0, ev_tx_ready = 1'b0, ev_tx_underrun = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [3:0] m_flags = '0;
  logic [3:0] m_mask = '0;

  always #10 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
    .ev_rx_ready(ev_rx_ready), .ev_rx_overrun(ev_rx_overrun),
    .ev_tx_ready(ev_tx_ready), .ev_tx_underrun(ev_tx_underrun), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic observe(input string tag);
    reg_addr = 4'd0; #1;
    check({tag, " flags"}, reg_rd_data, {28'd0, m_flags});
    reg_addr = 4'd1; #1;
    check({tag, " mask"}, reg_rd_data, {28'd0, m_mask});
    check({tag, " irq R6"}, {31'd0, irq}, {31'd0, |(m_flags & m_mask)});
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic step(input logic [3:0] a, input bit we, input logic [31:0] d,
                      input logic [3:0] ev, input string tag);
    reg_addr = a; reg_wr_en = we; reg_wr_data = d;
    {ev_tx_underrun, ev_tx_ready, ev_rx_overrun, ev_rx_ready} = ev;
    @(posedge clk);
    if (we) begin
      case (a)
        4'd2: m_mask  = m_mask | d[3:0];
        4'd3: m_mask  = m_mask & ~d[3:0];
        4'd4: m_flags = m_flags & ~d[3:0];
        4'd5: m_flags = m_flags | d[3:0];
        default: ;
      endcase
    end
    m_flags = m_flags | ev;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_data = '0;
    {ev_tx_underrun, ev_tx_ready, ev_rx_overrun, ev_rx_ready} = 4'd0;
    observe(tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_flags = '0; m_mask = '0;
    repeat (3) @(negedge clk);
    observe("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    observe("R1 after reset");
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(4'd6, 1'b0, 0, 4'b0001, "R2 rx ready event");
    step(4'd0, 1'b0, 0, 4'b0000, "R3 hold 1");
    step(4'd0, 1'b0, 0, 4'b0000, "R3 hold 2");
    step(4'd2, 1'b1, 32'h0, 4'b0000, "R4 mask-on zero data");
    step(4'd2, 1'b1, 32'hFFFF_FFF0, 4'b0000, "R4 mask-on upper bits");
    step(4'd2, 1'b1, 32'h1, 4'b0000, "R4 mask-on bit0 R6");
    step(4'd0, 1'b0, 0, 4'b0100, "R2 tx ready event");
    step(4'd4, 1'b1, 32'h4, 4'b0000, "R7 clear masked-off bit keeps irq");
    step(4'd4, 1'b1, 32'h1, 4'b0000, "R7 clear drops irq");
    step(4'd5, 1'b1, 32'h8, 4'b0000, "R8 force bit3 masked");
    step(4'd2, 1'b1, 32'h8, 4'b0000, "R8 unmask forced bit");
    step(4'd3, 1'b1, 32'h8, 4'b0000, "R5 mask-off bit3");
    step(4'd3, 1'b1, 32'h0, 4'b0000, "R5 mask-off zero data");
    step(4'd4, 1'b1, 32'h2, 4'b0010, "R9 event beats clear");
    step(4'd0, 1'b1, 32'hF, 4'b0000, "R10 write to flags ignored");
    step(4'd1, 1'b1, 32'hF, 4'b0000, "R10 write to mask ignored");
    for (int a = 2; a < 8; a++) begin
      reg_addr = 4'(a); #1;
      check("R10 command address reads zero", reg_rd_data, 32'd0);
    end
    for (int i = 0; i < 300; i++) begin
      step(4'((i * 5) % 7), ((i % 3) != 0), 32'(i * 37 + (i >> 2)),
           4'(((i * 11) >> 2) & ((i % 4 == 0) ? 15 : 3)), "R6 mixed traffic");
    end
    step(4'd5, 1'b1, 32'hF, 4'b0000, "R8 force all");
    step(4'd2, 1'b1, 32'hF, 4'b0000, "R4 unmask all");
    do_reset();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule